// File: doc/BRIEF.md
# Paced Memory Increment Relocator

This block moves the contents of one physical memory increment into a spare increment. It does not copy the whole increment in one step. The increment is split into fixed sub-blocks, and each sub-block is copied word by word while the rest of the system holds a pause. Between two sub-blocks the block releases the pause and waits for a programmed number of idle cycles, so that normal work and I/O keep making progress. The absolute-to-physical mapping entry is rewritten only after the last sub-block has been copied. Until then, any access made outside a pause still lands on the source increment.

A controller issues a command that names a source increment, a destination increment, the absolute increment index to remap, and a gap length. It also supplies a vector that marks which physical increments are currently in use. The block rejects a command whose destination is already occupied or is the same as the source, because a destination in either state would leave an absolute increment without a unique backing. The memory port is a simple master with one word per cycle and a read latency of one cycle. The increment size, sub-block size, increment counts and gap width are all parameters, so a testbench can use small sizes.

Top module: `incr_relocator`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `pause_req`, `mem_rd`, `mem_wr`, `map_we` and `cmd_err` are all 0.
- R2: After an accepted command completes, every word at offset i of the destination increment equals the value that word i of the source held when the command was accepted. No other increment is written.
- R3: `mem_rd` and `mem_wr` are only asserted while both `pause_req` and `pause_gnt` are 1. Before each sub-block, the block holds `pause_req` and waits for `pause_gnt`.
- R4: One increment is copied in exactly 2^(INC_LG-SUB_LG) pause windows. Each window contains exactly 2^SUB_LG reads and 2^SUB_LG writes, and `pause_req` falls in the cycle after the last write of the window.
- R5: Between two consecutive pause windows of one command, `pause_req` stays low for exactly G+1 cycles, where G is the `cmd_gap` value sampled when the command was accepted.
- R6: Each accepted command produces exactly one `map_we` pulse. It occurs in the cycle after the final write, with `pause_req` low, `map_idx` equal to the command's absolute index and `map_phys` equal to the destination. No `map_we` occurs earlier.
- R7: A command whose destination has its `phys_busy` bit set, or whose destination equals its source, is rejected. `cmd_err` pulses high for one cycle in the cycle after `cmd_valid`, and no memory access, pause request or map write follows.
- R8: While `cmd_ready` is 0, `cmd_valid` and all command fields, including `cmd_gap`, are ignored. They neither raise `cmd_err` nor change the running transfer.
- R9: Within a command, the word offset starts at 0 and rises by one per copied word. Each write to destination offset i directly follows, in the next cycle, a read of source offset i. The physical word address is increment × 2^INC_LG + offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled when `cmd_ready` is 1 |
| cmd_src | input | PI_W | Source physical increment |
| cmd_dst | input | PI_W | Destination physical increment |
| cmd_abs | input | AI_W | Absolute increment index to remap |
| cmd_gap | input | GAP_W | Idle gap between sub-blocks, in cycles minus one |
| phys_busy | input | NUM_PHYS | One bit per physical increment that is in use |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_err | output | 1 | One-cycle reject pulse |
| pause_req | output | 1 | Request to pause system memory traffic |
| pause_gnt | input | 1 | System confirms the pause |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | PI_W+INC_LG | Physical word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after `mem_rd` |
| map_we | output | 1 | Mapping table write strobe |
| map_idx | output | AI_W | Absolute increment index being remapped |
| map_phys | output | PI_W | New physical increment for `map_idx` |

## Verification
The bench varies the grant latency and the gap length. A zero gap tests the shortest possible release of the pause, and the maximum gap tests that the counter does not wrap. A block that reused a stale grant or miscounted the gap would break the exact low-time check or touch memory without the pause. Directed commands aimed at an occupied destination, or at a destination equal to the source, test the reject path; a design that let those through would corrupt an increment that is in use. A spurious command issued mid-transfer with a different gap and destination tests that the latched command stays fixed; a design that let the new fields through would remap the wrong entry or space its windows wrongly. Checking the map write against the final write shows whether the remap could come early, which would expose the half-copied destination.

// File: rtl/relo_pkg.sv
package relo_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_REQ,
    RS_RD,
    RS_WR,
    RS_GAP,
    RS_MAP
  } relo_state_e;

  // Number of sub-blocks that make up one increment.
  function automatic int unsigned subs_per_inc(int unsigned inc_lg, int unsigned sub_lg);
    return 32'd1 << (inc_lg - sub_lg);
  endfunction

endpackage

// File: rtl/relo_walker.sv
module relo_walker #(
  parameter int INC_LG = 6,
  parameter int SUB_LG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [INC_LG-1:0] off,
  output logic              sub_end,
  output logic              inc_end
);
  localparam int SI_W = INC_LG - SUB_LG;
  localparam int SUBS = int'(relo_pkg::subs_per_inc(INC_LG, SUB_LG));

  logic [SUB_LG-1:0] word_idx;
  logic [SI_W-1:0]   sub_idx;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      word_idx <= '0;
      sub_idx  <= '0;
    end else if (step) begin
      word_idx <= word_idx + 1'b1;
      if (sub_end) sub_idx <= sub_idx + 1'b1;
    end
  end

  assign off     = {sub_idx, word_idx};
  assign sub_end = (word_idx == '1);
  assign inc_end = sub_end && (sub_idx == SI_W'(SUBS - 1));
endmodule

// File: rtl/relo_gap_timer.sv
module relo_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             expired
);
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/incr_relocator.sv
module incr_relocator
  import relo_pkg::*;
#(
  parameter  int DATA_W   = 32,
  parameter  int NUM_PHYS = 8,
  parameter  int NUM_ABS  = 8,
  parameter  int INC_LG   = 6,
  parameter  int SUB_LG   = 3,
  parameter  int GAP_W    = 8,
  localparam int PI_W     = $clog2(NUM_PHYS),
  localparam int AI_W     = $clog2(NUM_ABS),
  localparam int PA_W     = PI_W + INC_LG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [PI_W-1:0]     cmd_src,
  input  logic [PI_W-1:0]     cmd_dst,
  input  logic [AI_W-1:0]     cmd_abs,
  input  logic [GAP_W-1:0]    cmd_gap,
  input  logic [NUM_PHYS-1:0] phys_busy,
  output logic                cmd_ready,
  output logic                cmd_err,
  output logic                pause_req,
  input  logic                pause_gnt,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [PA_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                map_we,
  output logic [AI_W-1:0]     map_idx,
  output logic [PI_W-1:0]     map_phys
);

  function automatic logic [PA_W-1:0] word_addr(logic [PI_W-1:0] inc, logic [INC_LG-1:0] off);
    return {inc, off};
  endfunction

  relo_state_e      st, st_nx;
  logic [PI_W-1:0]  src_q, dst_q;
  logic [AI_W-1:0]  abs_q;
  logic [GAP_W-1:0] gap_q;
  logic             err_q;

  logic [INC_LG-1:0] w_off;
  logic              w_sub_end, w_inc_end;
  logic              gap_expired;

  // Named internal events, observed by the bound checker.
  logic idle, cmd_bad, ev_accept, ev_reject;
  logic ev_word_copy, ev_sub_end, ev_copy_end;

  assign idle         = (st == RS_IDLE);
  assign cmd_bad      = phys_busy[cmd_dst] || (cmd_dst == cmd_src);
  assign ev_accept    = idle && cmd_valid && !cmd_bad;
  assign ev_reject    = idle && cmd_valid && cmd_bad;
  assign ev_word_copy = (st == RS_WR);
  assign ev_sub_end   = ev_word_copy && w_sub_end && !w_inc_end;
  assign ev_copy_end  = ev_word_copy && w_inc_end;

  relo_walker #(.INC_LG(INC_LG), .SUB_LG(SUB_LG)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ev_accept),
    .step    (ev_word_copy),
    .off     (w_off),
    .sub_end (w_sub_end),
    .inc_end (w_inc_end)
  );

  relo_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_sub_end),
    .load_val (gap_q),
    .expired  (gap_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= RS_IDLE;
      src_q <= '0;
      dst_q <= '0;
      abs_q <= '0;
      gap_q <= '0;
      err_q <= 1'b0;
    end else begin
      st    <= st_nx;
      err_q <= ev_reject;
      if (ev_accept) begin
        src_q <= cmd_src;
        dst_q <= cmd_dst;
        abs_q <= cmd_abs;
        gap_q <= cmd_gap;
      end
    end
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      RS_IDLE: if (ev_accept) st_nx = RS_REQ;
      RS_REQ:  if (pause_gnt) st_nx = RS_RD;
      RS_RD:   st_nx = RS_WR;
      RS_WR: begin
        if (w_inc_end)      st_nx = RS_MAP;
        else if (w_sub_end) st_nx = RS_GAP;
        else                st_nx = RS_RD;
      end
      RS_GAP:  if (gap_expired) st_nx = RS_REQ;
      RS_MAP:  st_nx = RS_IDLE;
      default: st_nx = RS_IDLE;
    endcase
  end

  assign cmd_ready = idle;
  assign cmd_err   = err_q;
  assign pause_req = (st == RS_REQ) || (st == RS_RD) || (st == RS_WR);
  assign mem_rd    = (st == RS_RD);
  assign mem_wr    = ev_word_copy;
  assign mem_addr  = mem_wr ? word_addr(dst_q, w_off) : word_addr(src_q, w_off);
  assign mem_wdata = mem_rdata;
  assign map_we    = (st == RS_MAP);
  assign map_idx   = abs_q;
  assign map_phys  = dst_q;

endmodule

// File: rtl/relo_chk.sv
module relo_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_rd,
  input logic mem_wr,
  input logic pause_req,
  input logic pause_gnt,
  input logic map_we,
  input logic cmd_err,
  input logic ev_copy_end
);
  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !pause_req && !map_we) else $error("reset state"); // R1
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> $past(mem_rd)) else $error("write without read"); // R2
  AST_ACCESS_PAUSED: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd || mem_wr) |-> (pause_req && pause_gnt)) else $error("access outside pause"); // R3
  AST_PAUSE_DROP: assert property (@(posedge clk) disable iff (!rst_n) $fell(pause_req) |-> $past(mem_wr)) else $error("pause dropped early"); // R4
  AST_MAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) map_we |-> $past(ev_copy_end) && !pause_req) else $error("early remap"); // R6
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cmd_err |-> !pause_req && !mem_rd && !mem_wr && !map_we) else $error("reject not quiet"); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mem_rd, mem_wr, map_we})) else $error("strobe overlap"); // R9
endmodule

bind incr_relocator relo_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .pause_req   (pause_req),
  .pause_gnt   (pause_gnt),
  .map_we      (map_we),
  .cmd_err     (cmd_err),
  .ev_copy_end (ev_copy_end)
);

// File: tb/sim_incr_relocator.sv
module sim_incr_relocator;
  localparam int DW = 32, NP = 8, NA = 8, INC_LG = 6, SUB_LG = 3, GW = 8;
  localparam int PI_W = $clog2(NP), AI_W = $clog2(NA);
  localparam int INC = 1 << INC_LG, SUB = 1 << SUB_LG;
  localparam int WORDS = NP * INC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [PI_W-1:0] cmd_src = '0, cmd_dst = '0;
  logic [AI_W-1:0] cmd_abs = '0;
  logic [GW-1:0] cmd_gap = '0;
  logic [NP-1:0] phys_busy = '0;
  logic cmd_ready, cmd_err, pause_req, mem_rd, mem_wr, map_we;
  logic pause_gnt = 1'b0;
  logic [PI_W+INC_LG-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [AI_W-1:0] map_idx;
  logic [PI_W-1:0] map_phys;

  always #2 clk = ~clk;

  incr_relocator #(.DATA_W(DW), .NUM_PHYS(NP), .NUM_ABS(NA), .INC_LG(INC_LG),
                   .SUB_LG(SUB_LG), .GAP_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
    .cmd_abs(cmd_abs), .cmd_gap(cmd_gap), .phys_busy(phys_busy), .cmd_ready(cmd_ready),
    .cmd_err(cmd_err), .pause_req(pause_req), .pause_gnt(pause_gnt), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .map_we(map_we), .map_idx(map_idx), .map_phys(map_phys));

  // Behavioural memory and pause grant model
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] snap [WORDS];
  int gnt_lat = 0, gnt_cnt = 0;
  initial mem_rdata = '0;

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (!rst_n || !pause_req) begin
      pause_gnt <= 1'b0;
      gnt_cnt   <= 0;
    end else if (gnt_cnt >= gnt_lat) pause_gnt <= 1'b1;
    else gnt_cnt <= gnt_cnt + 1;
  end

  // Expected-value functions
  function automatic int exp_windows();           return 1 << (INC_LG - SUB_LG); endfunction
  function automatic int exp_low(int g);          return g + 1; endfunction
  function automatic int exp_addr(int inc, int o); return inc * INC + o; endfunction
  function automatic bit exp_reject(int s, int d, logic [NP-1:0] b); return b[d] || (s == d); endfunction

  int compared = 0, mismatched = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor, sampled on the falling edge
  int e_src, e_dst, e_abs, e_gap;
  int off, windows, win_wr, low_cnt, maps, errs, accs;
  int bad_acc, bad_addr, bad_win, bad_drop, bad_gap, bad_map;
  bit prev_rd, prev_wr, prev_req;

  task automatic clear_mon();
    off = 0; windows = 0; win_wr = 0; low_cnt = 0; maps = 0; errs = 0; accs = 0;
    bad_acc = 0; bad_addr = 0; bad_win = 0; bad_drop = 0; bad_gap = 0; bad_map = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd || mem_wr) begin
        accs++;
        if (!(pause_req && pause_gnt)) bad_acc++;
      end
      if (mem_rd && int'(mem_addr) != exp_addr(e_src, off)) bad_addr++;
      if (mem_wr) begin
        if (int'(mem_addr) != exp_addr(e_dst, off) || !prev_rd) bad_addr++;
        off++;
        win_wr++;
      end
      if (pause_req && !prev_req) begin
        windows++;
        if (windows >= 2 && low_cnt != exp_low(e_gap)) bad_gap++;
        win_wr = 0;
      end
      if (!pause_req && prev_req) begin
        if (win_wr != SUB) bad_win++;
        if (!prev_wr) bad_drop++;
      end
      if (!pause_req) low_cnt++; else low_cnt = 0;
      if (map_we) begin
        maps++;
        if (int'(map_idx) != e_abs || int'(map_phys) != e_dst) bad_map++;
        if (pause_req || !prev_wr || off != INC) bad_map++;
      end
      if (cmd_err) errs++;
    end
    prev_rd = mem_rd; prev_wr = mem_wr; prev_req = pause_req;
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic run_cmd(int s, int d, int a, int g, logic [NP-1:0] busy, int lat, bit poke);
    bit rej;
    int diff_dst, diff_oth, waitc;
    rej = exp_reject(s, d, busy);
    @(posedge clk); #1;
    clear_mon();
    e_src = s; e_dst = d; e_abs = a; e_gap = g;
    gnt_lat = lat;
    for (int i = 0; i < WORDS; i++) snap[i] = mem[i];
    @(negedge clk);
    cmd_valid = 1'b1; cmd_src = PI_W'(s); cmd_dst = PI_W'(d);
    cmd_abs = AI_W'(a); cmd_gap = GW'(g); phys_busy = busy;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_gap = GW'(g + 3);
    if (rej) begin
      chk(cmd_err == 1'b1, "R7", "reject pulse", int'(cmd_err), 1);
      repeat (6) @(negedge clk);
      chk(accs == 0 && windows == 0 && maps == 0, "R7", "activity after reject", accs + windows + maps, 0);
      chk(errs == 1, "R7", "reject pulse width", errs, 1);
      chk(cmd_ready == 1'b1, "R7", "ready after reject", int'(cmd_ready), 1);
      return;
    end
    if (poke) begin
      repeat (10) @(negedge clk);
      cmd_valid = 1'b1; cmd_src = PI_W'(d); cmd_dst = PI_W'((d + 1) % NP);
      cmd_abs = AI_W'(a + 1); cmd_gap = GW'(g + 7);
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    waitc = 0;
    while (!cmd_ready && waitc < 50000) begin @(negedge clk); waitc++; end
    diff_dst = 0; diff_oth = 0;
    for (int i = 0; i < WORDS; i++) begin
      if (i / INC == d) begin
        if (mem[i] != snap[exp_addr(s, i % INC)]) diff_dst++;
      end else if (mem[i] != snap[i]) diff_oth++;
    end
    chk(diff_dst == 0, "R2", "destination words differing from source", diff_dst, 0);
    chk(diff_oth == 0, "R2", "other words changed", diff_oth, 0);
    chk(bad_addr == 0, "R9", "address/order errors", bad_addr, 0);
    chk(bad_acc == 0, "R3", "accesses outside granted pause", bad_acc, 0);
    chk(windows == exp_windows(), "R4", "pause windows", windows, exp_windows());
    chk(bad_win == 0 && bad_drop == 0, "R4", "window shape errors", bad_win + bad_drop, 0);
    chk(bad_gap == 0, "R5", "gap length errors", bad_gap, 0);
    chk(maps == 1, "R6", "map writes", maps, 1);
    chk(bad_map == 0, "R6", "map content/timing errors", bad_map, 0);
    chk(errs == 0, "R8", "error pulses during transfer", errs, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < WORDS; i++) mem[i] = $urandom;
    clear_mon();
    e_src = 0; e_dst = 0; e_abs = 0; e_gap = 0;
    repeat (3) @(negedge clk);
    // R1 reset state, in reset and just after
    chk(cmd_ready && !pause_req && !mem_rd && !mem_wr && !map_we && !cmd_err, "R1", "state in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !pause_req && !mem_rd && !mem_wr && !map_we && !cmd_err, "R1", "state after reset", 0, 0);

    run_cmd(1, 2, 3, 0, 8'b0000_0010, 0, 1'b0);   // zero gap, immediate grant
    run_cmd(2, 5, 0, 255, 8'b0000_0100, 2, 1'b0); // widest gap, late grant
    run_cmd(0, 3, 6, 4, 8'b0000_1001, 1, 1'b0);   // R7 destination busy
    run_cmd(4, 4, 1, 2, 8'b0001_0000, 0, 1'b0);   // R7 destination equals source
    run_cmd(6, 7, 2, 5, 8'b1100_0000, 1, 1'b0);   // R7 busy destination plus busy source
    run_cmd(3, 6, 5, 3, 8'b0000_1000, 1, 1'b1);   // R8 spurious command mid-transfer
    for (int k = 0; k < 6; k++) begin
      int s, d, g, l;
      logic [NP-1:0] b;
      s = $urandom_range(0, NP - 1);
      d = $urandom_range(0, NP - 1);
      if (d == s) d = (s + 1) % NP;
      g = $urandom_range(0, 20);
      l = $urandom_range(0, 3);
      b = NP'($urandom);
      b[d] = 1'b0; b[s] = 1'b1;
      run_cmd(s, d, $urandom_range(0, NA - 1), g, b, l, k[0]);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule